// File: doc/BRIEF.md
# Instruction Operand Selection Decoder

This block is the second decode stage for a 32-bit fixed-length RISC instruction word. A primary opcode table (outside this block) has already classified the instruction and produced small selector codes that say where each operand comes from, where the result goes, how the record flag is formed and which single-bit behaviour flags apply. This block combines those codes with the raw instruction bits. It produces the request records the execute stage consumes. Each record is a data field plus a valid bit.

The outputs cover three general-register reads, two special-register reads, one immediate, one general-register write, one special-register write, the record flag, the overflow-enable flag, a group of eleven pass-through behaviour flags and the link bit. The block is purely combinational. Every data field is forced to zero whenever its valid bit is clear, so downstream comparators never see stale indices.

Bit positions below count from bit 0 = least significant bit of the instruction. The fields are:
- RT/RS: bits 25:21
- RA: bits 20:16
- RB: bits 15:11
- 16-bit immediate: bits 15:0
- 24-bit branch target: bits 25:2
- 14-bit displacement: bits 15:2
- overflow enable: bit 10
- record and link bits: bit 0

Special-register identifiers are 10 bits wide. The count register is 9 and the link register is 8. Immediates are XLEN (default 64) bits wide.

Top module: `opsel_decode`

## Requirements
- R1: First-operand select code 1 drives read port 1 with RA and sets its valid bit. Code 2 does the same when RA is nonzero, and clears the valid bit when RA is 0. Codes 0 and 3 leave read port 1 invalid.
- R2: Third-operand select code 1 drives read port 3 with RS (bits 25:21) and sets its valid bit. Code 0 leaves it invalid.
- R3: For operation class 1 (conditional branch) and class 2 (branch to register), special-read port 1 requests identifier 9 with valid set when instruction bit 23 is clear. When bit 23 is set, the port stays invalid.
- R4: For operation class 3 (move from special register) and class 4 (move to special register), special-read port 1 is valid. Its identifier takes instruction bits 15:11 as its upper five bits and bits 20:16 as its lower five bits.
- R5: Second-operand select code 1 drives read port 2 with RB and sets its valid bit, with the immediate invalid. Code 0 clears both the read port 2 and immediate valid bits.
- R6: Second-operand select code 12 clears the immediate and read port 2 valid bits and sets the special-read port 2 valid bit. The identifier is 9 if instruction bit 10 is set, and 8 otherwise.
- R7: Immediate codes produce a valid immediate as follows:
  - code 2: the 16-bit field zero-extended
  - code 3: the 16-bit field sign-extended
  - code 9: all ones
  - code 10: the 6-bit shift {bit 1, bits 15:11} zero-extended
  - code 11: bits 15:11 zero-extended
- R8: Code 6 gives the sign-extended 24-bit target shifted left by 2. Codes 7 and 8 give the sign-extended 14-bit displacement shifted left by 2. All three are valid.
- R9: Code 4 places the 16-bit field in bits 31:16 and zero-extends it. Code 5 does the same and sign-extends it. Both are valid.
- R10: Output select code 3 sets only the special-write valid bit, with the identifier formed as in R4. Code 0 clears both write valid bits. Code 1 (RT) and code 2 (RA) set only the register-write valid bit, with that destination.
- R11: The record and overflow-enable valid bits are always set. The record value is 0 for record-select code 0, 1 for code 1, instruction bit 0 for code 2, and 0 for code 3. The overflow-enable value is instruction bit 10.
- R12: The eleven behaviour flags pass through unchanged. The link output equals instruction bit 0 when the link-permit input is set, and 0 otherwise.
- R13: Second-operand select codes 13 to 15 leave the immediate, read port 2 and special-read port 2 all invalid.
- R14: Every data output whose valid bit is clear is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Raw instruction word |
| in1_sel_i | input | 2 | First operand select code |
| in2_sel_i | input | 4 | Second operand / immediate select code |
| in3_sel_i | input | 1 | Third operand select code |
| out_sel_i | input | 2 | Destination select code |
| rc_sel_i | input | 2 | Record flag select code |
| op_cls_i | input | 3 | Operation class |
| op_flags_i | input | 11 | Behaviour flags from primary decode |
| lk_en_i | input | 1 | Operation permits linking |
| rd1_idx_o | output | 5 | Read port 1 register index |
| rd1_vld_o | output | 1 | Read port 1 valid |
| rd2_idx_o | output | 5 | Read port 2 register index |
| rd2_vld_o | output | 1 | Read port 2 valid |
| rd3_idx_o | output | 5 | Read port 3 register index |
| rd3_vld_o | output | 1 | Read port 3 valid |
| sprr1_id_o | output | 10 | Special-read port 1 identifier |
| sprr1_vld_o | output | 1 | Special-read port 1 valid |
| sprr2_id_o | output | 10 | Special-read port 2 identifier |
| sprr2_vld_o | output | 1 | Special-read port 2 valid |
| imm_o | output | XLEN | Immediate value |
| imm_vld_o | output | 1 | Immediate valid |
| wr_idx_o | output | 5 | Register write index |
| wr_vld_o | output | 1 | Register write valid |
| sprw_id_o | output | 10 | Special-write identifier |
| sprw_vld_o | output | 1 | Special-write valid |
| rc_o | output | 1 | Record flag value |
| rc_vld_o | output | 1 | Record flag valid |
| oe_o | output | 1 | Overflow-enable value |
| oe_vld_o | output | 1 | Overflow-enable valid |
| ex_flags_o | output | 11 | Behaviour flags to execute |
| lk_o | output | 1 | Link bit |

## Verification
The bound checker continuously enforces these rules:
- the zero-RA suppression of read port 1
- the count-register request for branches
- the mutual exclusion of the special-register second operand with the register and immediate paths
- the rejection of undefined immediate codes
- the exclusivity of the two write records
- the all-ones constant
- the zeroing of an invalid immediate

Exact values can only be shown by the bench's directed and random scenarios, compared against an independent model. These include each shifted or sign-extended immediate, the swapped-halves special-register identifier, the destination and record-flag choices, and the link gating.

// File: rtl/opsel_pkg.sv
package opsel_pkg;

   typedef enum logic [1:0] {
      IN1_NONE = 2'd0,
      IN1_RA   = 2'd1,
      IN1_RA0  = 2'd2
   } in1_sel_e;

   typedef enum logic [3:0] {
      IN2_NONE  = 4'd0,
      IN2_RB    = 4'd1,
      IN2_UI    = 4'd2,
      IN2_SI    = 4'd3,
      IN2_UI_HI = 4'd4,
      IN2_SI_HI = 4'd5,
      IN2_LI    = 4'd6,
      IN2_BD    = 4'd7,
      IN2_DS    = 4'd8,
      IN2_M1    = 4'd9,
      IN2_SH    = 4'd10,
      IN2_SH32  = 4'd11,
      IN2_SPR   = 4'd12
   } in2_sel_e;

   typedef enum logic [1:0] {
      OUT_NONE = 2'd0,
      OUT_RT   = 2'd1,
      OUT_RA   = 2'd2,
      OUT_SPR  = 2'd3
   } out_sel_e;

   typedef enum logic [1:0] {
      RCS_ZERO = 2'd0,
      RCS_ONE  = 2'd1,
      RCS_BIT  = 2'd2
   } rc_sel_e;

   typedef enum logic [2:0] {
      CLS_OTHER = 3'd0,
      CLS_BC    = 3'd1,
      CLS_BCREG = 3'd2,
      CLS_MFSPR = 3'd3,
      CLS_MTSPR = 3'd4
   } op_cls_e;

   // Decoded instruction fields, least-significant-bit numbering
   typedef struct packed {
      logic [4:0]  rt;       // 25:21, also RS and branch options
      logic [4:0]  ra;       // 20:16
      logic [4:0]  rb;       // 15:11
      logic [15:0] d16;      // 15:0
      logic [23:0] li;       // 25:2
      logic [13:0] bd;       // 15:2
      logic [9:0]  spr;      // {15:11, 20:16}
      logic [5:0]  sh;       // {1, 15:11}
      logic        no_ctr;   // 23: branch does not use the count register
      logic        xo_top;   // 10: selects count vs link register
      logic        oe;       // 10
      logic        rc;       // 0
      logic        lk;       // 0
   } fld_t;

endpackage

// File: rtl/opsel_fields.sv
module opsel_fields
   import opsel_pkg::*;
(
   input  logic [31:0] instr_i,
   output fld_t        fld_o
);

   always_comb begin
      fld_o.rt     = instr_i[25:21];
      fld_o.ra     = instr_i[20:16];
      fld_o.rb     = instr_i[15:11];
      fld_o.d16    = instr_i[15:0];
      fld_o.li     = instr_i[25:2];
      fld_o.bd     = instr_i[15:2];
      fld_o.spr    = {instr_i[15:11], instr_i[20:16]};
      fld_o.sh     = {instr_i[1], instr_i[15:11]};
      fld_o.no_ctr = instr_i[23];
      fld_o.xo_top = instr_i[10];
      fld_o.oe     = instr_i[10];
      fld_o.rc     = instr_i[0];
      fld_o.lk     = instr_i[0];
   end

endmodule

// File: rtl/opsel_src.sv
module opsel_src
   import opsel_pkg::*;
#(
   parameter int REG_W  = 5,
   parameter int SPR_W  = 10,
   parameter int CTR_ID = 9,
   parameter int LR_ID  = 8
) (
   input  fld_t             fld_i,
   input  logic [1:0]       in1_sel_i,
   input  logic [3:0]       in2_sel_i,
   input  logic             in3_sel_i,
   input  logic [2:0]       op_cls_i,
   output logic [REG_W-1:0] rd1_idx_o,
   output logic             rd1_vld_o,
   output logic [REG_W-1:0] rd2_idx_o,
   output logic             rd2_vld_o,
   output logic [REG_W-1:0] rd3_idx_o,
   output logic             rd3_vld_o,
   output logic [SPR_W-1:0] sprr1_id_o,
   output logic             sprr1_vld_o,
   output logic [SPR_W-1:0] sprr2_id_o,
   output logic             sprr2_vld_o
);

   localparam logic [SPR_W-1:0] CtrId = SPR_W'(CTR_ID);
   localparam logic [SPR_W-1:0] LrId  = SPR_W'(LR_ID);

   logic ra_zero;
   logic is_branch;
   logic is_move;

   assign ra_zero   = (fld_i.ra == '0);
   assign is_branch = (op_cls_i == CLS_BC) || (op_cls_i == CLS_BCREG);
   assign is_move   = (op_cls_i == CLS_MFSPR) || (op_cls_i == CLS_MTSPR);

   // first operand
   always_comb begin
      rd1_vld_o = 1'b0;
      rd1_idx_o = '0;
      case (in1_sel_i)
         IN1_RA: begin
            rd1_vld_o = 1'b1;
            rd1_idx_o = fld_i.ra;
         end
         IN1_RA0: begin
            rd1_vld_o = !ra_zero;
            rd1_idx_o = ra_zero ? '0 : fld_i.ra;
         end
         default: ;
      endcase
   end

   // special-register read 1: branch counter or move identifier
   always_comb begin
      sprr1_vld_o = 1'b0;
      sprr1_id_o  = '0;
      if (is_branch && !fld_i.no_ctr) begin
         sprr1_vld_o = 1'b1;
         sprr1_id_o  = CtrId;
      end else if (is_move) begin
         sprr1_vld_o = 1'b1;
         sprr1_id_o  = fld_i.spr;
      end
   end

   // second operand: register or special register path
   always_comb begin
      rd2_vld_o   = 1'b0;
      rd2_idx_o   = '0;
      sprr2_vld_o = 1'b0;
      sprr2_id_o  = '0;
      case (in2_sel_i)
         IN2_RB: begin
            rd2_vld_o = 1'b1;
            rd2_idx_o = fld_i.rb;
         end
         IN2_SPR: begin
            sprr2_vld_o = 1'b1;
            sprr2_id_o  = fld_i.xo_top ? CtrId : LrId;
         end
         default: ;
      endcase
   end

   // third operand
   assign rd3_vld_o = in3_sel_i;
   assign rd3_idx_o = in3_sel_i ? fld_i.rt : '0;

endmodule

// File: rtl/opsel_imm.sv
module opsel_imm
   import opsel_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  fld_t            fld_i,
   input  logic [3:0]      in2_sel_i,
   output logic [XLEN-1:0] imm_o,
   output logic            imm_vld_o
);

   logic [XLEN-1:0] ui_lo, si_lo, ui_hi, si_hi, li_x, bd_x, sh_x, sh32_x;

   assign ui_lo  = {{(XLEN-16){1'b0}}, fld_i.d16};
   assign si_lo  = {{(XLEN-16){fld_i.d16[15]}}, fld_i.d16};
   assign li_x   = {{(XLEN-26){fld_i.li[23]}}, fld_i.li, 2'b00};
   assign bd_x   = {{(XLEN-16){fld_i.bd[13]}}, fld_i.bd, 2'b00};
   assign sh_x   = {{(XLEN-6){1'b0}}, fld_i.sh};
   assign sh32_x = {{(XLEN-5){1'b0}}, fld_i.sh[4:0]};

   // high-half forms: width variant picked at elaboration
   generate
      if (XLEN > 32) begin : g_wide
         assign ui_hi = {{(XLEN-32){1'b0}}, fld_i.d16, 16'h0000};
         assign si_hi = {{(XLEN-32){fld_i.d16[15]}}, fld_i.d16, 16'h0000};
      end else begin : g_narrow
         assign ui_hi = {fld_i.d16, 16'h0000};
         assign si_hi = {fld_i.d16, 16'h0000};
      end
   endgenerate

   always_comb begin
      imm_vld_o = 1'b1;
      imm_o     = '0;
      case (in2_sel_i)
         IN2_UI:    imm_o = ui_lo;
         IN2_SI:    imm_o = si_lo;
         IN2_UI_HI: imm_o = ui_hi;
         IN2_SI_HI: imm_o = si_hi;
         IN2_LI:    imm_o = li_x;
         IN2_BD:    imm_o = bd_x;
         IN2_DS:    imm_o = bd_x;
         IN2_M1:    imm_o = '1;
         IN2_SH:    imm_o = sh_x;
         IN2_SH32:  imm_o = sh32_x;
         default:   imm_vld_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/opsel_dst.sv
module opsel_dst
   import opsel_pkg::*;
#(
   parameter int REG_W   = 5,
   parameter int SPR_W   = 10,
   parameter int NFLAGS  = 11
) (
   input  fld_t              fld_i,
   input  logic [1:0]        out_sel_i,
   input  logic [1:0]        rc_sel_i,
   input  logic [NFLAGS-1:0] op_flags_i,
   input  logic              lk_en_i,
   output logic [REG_W-1:0]  wr_idx_o,
   output logic              wr_vld_o,
   output logic [SPR_W-1:0]  sprw_id_o,
   output logic              sprw_vld_o,
   output logic              rc_o,
   output logic              rc_vld_o,
   output logic              oe_o,
   output logic              oe_vld_o,
   output logic [NFLAGS-1:0] ex_flags_o,
   output logic              lk_o
);

   always_comb begin
      wr_vld_o   = 1'b0;
      wr_idx_o   = '0;
      sprw_vld_o = 1'b0;
      sprw_id_o  = '0;
      case (out_sel_i)
         OUT_RT: begin
            wr_vld_o = 1'b1;
            wr_idx_o = fld_i.rt;
         end
         OUT_RA: begin
            wr_vld_o = 1'b1;
            wr_idx_o = fld_i.ra;
         end
         OUT_SPR: begin
            sprw_vld_o = 1'b1;
            sprw_id_o  = fld_i.spr;
         end
         default: ;
      endcase
   end

   always_comb begin
      case (rc_sel_i)
         RCS_ONE: rc_o = 1'b1;
         RCS_BIT: rc_o = fld_i.rc;
         default: rc_o = 1'b0;
      endcase
   end

   assign rc_vld_o = 1'b1;
   assign oe_o     = fld_i.oe;
   assign oe_vld_o = 1'b1;
   assign lk_o     = lk_en_i & fld_i.lk;

   generate
      for (genvar gi = 0; gi < NFLAGS; gi++) begin : g_flag
         assign ex_flags_o[gi] = op_flags_i[gi];
      end
   endgenerate

endmodule

// File: rtl/opsel_decode.sv
module opsel_decode
   import opsel_pkg::*;
#(
   parameter int XLEN   = 64,
   parameter int REG_W  = 5,
   parameter int SPR_W  = 10,
   parameter int NFLAGS = 11,
   parameter int CTR_ID = 9,
   parameter int LR_ID  = 8
) (
   input  logic [31:0]       instr_i,
   input  logic [1:0]        in1_sel_i,
   input  logic [3:0]        in2_sel_i,
   input  logic              in3_sel_i,
   input  logic [1:0]        out_sel_i,
   input  logic [1:0]        rc_sel_i,
   input  logic [2:0]        op_cls_i,
   input  logic [NFLAGS-1:0] op_flags_i,
   input  logic              lk_en_i,
   output logic [REG_W-1:0]  rd1_idx_o,
   output logic              rd1_vld_o,
   output logic [REG_W-1:0]  rd2_idx_o,
   output logic              rd2_vld_o,
   output logic [REG_W-1:0]  rd3_idx_o,
   output logic              rd3_vld_o,
   output logic [SPR_W-1:0]  sprr1_id_o,
   output logic              sprr1_vld_o,
   output logic [SPR_W-1:0]  sprr2_id_o,
   output logic              sprr2_vld_o,
   output logic [XLEN-1:0]   imm_o,
   output logic              imm_vld_o,
   output logic [REG_W-1:0]  wr_idx_o,
   output logic              wr_vld_o,
   output logic [SPR_W-1:0]  sprw_id_o,
   output logic              sprw_vld_o,
   output logic              rc_o,
   output logic              rc_vld_o,
   output logic              oe_o,
   output logic              oe_vld_o,
   output logic [NFLAGS-1:0] ex_flags_o,
   output logic              lk_o
);

   localparam int SprMax = (1 << SPR_W) - 1;

   // elaboration-time parameter checks
   generate
      if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
         $error("opsel_decode: XLEN must be 32 or 64");
      end
      if (REG_W != 5) begin : g_bad_regw
         $error("opsel_decode: register index fields are 5 bits");
      end
      if (SPR_W != 10) begin : g_bad_sprw
         $error("opsel_decode: special-register field is 10 bits");
      end
      if (NFLAGS < 1) begin : g_bad_nflags
         $error("opsel_decode: NFLAGS must be positive");
      end
      if (CTR_ID > SprMax || LR_ID > SprMax) begin : g_bad_ids
         $error("opsel_decode: special-register ids exceed SPR_W");
      end
   endgenerate

   fld_t fld;

   opsel_fields u_fields (
      .instr_i (instr_i),
      .fld_o   (fld)
   );

   opsel_src #(
      .REG_W  (REG_W),
      .SPR_W  (SPR_W),
      .CTR_ID (CTR_ID),
      .LR_ID  (LR_ID)
   ) u_src (
      .fld_i       (fld),
      .in1_sel_i   (in1_sel_i),
      .in2_sel_i   (in2_sel_i),
      .in3_sel_i   (in3_sel_i),
      .op_cls_i    (op_cls_i),
      .rd1_idx_o   (rd1_idx_o),
      .rd1_vld_o   (rd1_vld_o),
      .rd2_idx_o   (rd2_idx_o),
      .rd2_vld_o   (rd2_vld_o),
      .rd3_idx_o   (rd3_idx_o),
      .rd3_vld_o   (rd3_vld_o),
      .sprr1_id_o  (sprr1_id_o),
      .sprr1_vld_o (sprr1_vld_o),
      .sprr2_id_o  (sprr2_id_o),
      .sprr2_vld_o (sprr2_vld_o)
   );

   opsel_imm #(
      .XLEN (XLEN)
   ) u_imm (
      .fld_i     (fld),
      .in2_sel_i (in2_sel_i),
      .imm_o     (imm_o),
      .imm_vld_o (imm_vld_o)
   );

   opsel_dst #(
      .REG_W  (REG_W),
      .SPR_W  (SPR_W),
      .NFLAGS (NFLAGS)
   ) u_dst (
      .fld_i      (fld),
      .out_sel_i  (out_sel_i),
      .rc_sel_i   (rc_sel_i),
      .op_flags_i (op_flags_i),
      .lk_en_i    (lk_en_i),
      .wr_idx_o   (wr_idx_o),
      .wr_vld_o   (wr_vld_o),
      .sprw_id_o  (sprw_id_o),
      .sprw_vld_o (sprw_vld_o),
      .rc_o       (rc_o),
      .rc_vld_o   (rc_vld_o),
      .oe_o       (oe_o),
      .oe_vld_o   (oe_vld_o),
      .ex_flags_o (ex_flags_o),
      .lk_o       (lk_o)
   );

endmodule

// File: rtl/opsel_decode_chk.sv
module opsel_decode_chk #(
   parameter int XLEN = 64
) (
   input logic [31:0]     instr_i,
   input logic [1:0]      in1_sel_i,
   input logic [3:0]      in2_sel_i,
   input logic            in3_sel_i,
   input logic [2:0]      op_cls_i,
   input logic [4:0]      rd1_idx_o,
   input logic            rd1_vld_o,
   input logic            rd2_vld_o,
   input logic [4:0]      rd3_idx_o,
   input logic            rd3_vld_o,
   input logic [9:0]      sprr1_id_o,
   input logic            sprr1_vld_o,
   input logic            sprr2_vld_o,
   input logic [XLEN-1:0] imm_o,
   input logic            imm_vld_o,
   input logic            wr_vld_o,
   input logic            sprw_vld_o,
   input logic            rc_vld_o,
   input logic            oe_o,
   input logic            oe_vld_o
);

   always_comb begin
      if (in1_sel_i == 2'd2 && instr_i[20:16] == 5'd0) begin
         AST_RD1_ZERO_SUPPRESS: assert (!rd1_vld_o)
            else $error("read port 1 valid with zero base");  // R1
      end
      if (in1_sel_i == 2'd1) begin
         AST_RD1_RA: assert (rd1_vld_o && rd1_idx_o == instr_i[20:16])
            else $error("read port 1 not RA");  // R1
      end
      if (in3_sel_i) begin
         AST_RD3_RS: assert (rd3_vld_o && rd3_idx_o == instr_i[25:21])
            else $error("read port 3 not RS");  // R2
      end
      if ((op_cls_i == 3'd1 || op_cls_i == 3'd2) && !instr_i[23]) begin
         AST_BRANCH_CTR: assert (sprr1_vld_o && sprr1_id_o == 10'd9)
            else $error("branch missing counter read");  // R3
      end
      if (in2_sel_i == 4'd0) begin
         AST_IN2_NONE: assert (!imm_vld_o && !rd2_vld_o)
            else $error("second operand active for none");  // R5
      end
      if (in2_sel_i == 4'd12) begin
         AST_IN2_SPR_EXCL: assert (sprr2_vld_o && !imm_vld_o && !rd2_vld_o)
            else $error("special second operand not exclusive");  // R6
      end
      if (in2_sel_i == 4'd9) begin
         AST_MINUS_ONE: assert (imm_vld_o && imm_o == {XLEN{1'b1}})
            else $error("minus one constant wrong");  // R7
      end
      AST_WRITE_EXCL: assert (!(wr_vld_o && sprw_vld_o))
         else $error("both write records valid");  // R10
      AST_FLAGS_VALID: assert (rc_vld_o && oe_vld_o && oe_o == instr_i[10])
         else $error("record/overflow records wrong");  // R11
      if (in2_sel_i >= 4'd13) begin
         AST_BAD_IN2: assert (!imm_vld_o && !rd2_vld_o && !sprr2_vld_o)
            else $error("undefined second operand code active");  // R13
      end
      if (!imm_vld_o) begin
         AST_IMM_ZERO: assert (imm_o == '0)
            else $error("invalid immediate not zero");  // R14
      end
   end

endmodule

bind opsel_decode opsel_decode_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/sim_opsel_decode.sv
module sim_opsel_decode;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 200000;
   localparam int N_RANDOM   = 4000;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic [31:0] instr;
   logic [1:0]  in1, outs, rcs;
   logic [3:0]  in2;
   logic        in3, lken;
   logic [2:0]  cls;
   logic [10:0] flags;

   logic [4:0]  rd1_idx, rd2_idx, rd3_idx, wr_idx;
   logic        rd1_vld, rd2_vld, rd3_vld, wr_vld;
   logic [9:0]  s1_id, s2_id, sw_id;
   logic        s1_vld, s2_vld, sw_vld;
   logic [63:0] imm;
   logic        imm_vld, rc, rc_vld, oe, oe_vld, lk;
   logic [10:0] exf;

   opsel_decode u0 (
      .instr_i (instr), .in1_sel_i (in1), .in2_sel_i (in2), .in3_sel_i (in3),
      .out_sel_i (outs), .rc_sel_i (rcs), .op_cls_i (cls), .op_flags_i (flags),
      .lk_en_i (lken),
      .rd1_idx_o (rd1_idx), .rd1_vld_o (rd1_vld),
      .rd2_idx_o (rd2_idx), .rd2_vld_o (rd2_vld),
      .rd3_idx_o (rd3_idx), .rd3_vld_o (rd3_vld),
      .sprr1_id_o (s1_id), .sprr1_vld_o (s1_vld),
      .sprr2_id_o (s2_id), .sprr2_vld_o (s2_vld),
      .imm_o (imm), .imm_vld_o (imm_vld),
      .wr_idx_o (wr_idx), .wr_vld_o (wr_vld),
      .sprw_id_o (sw_id), .sprw_vld_o (sw_vld),
      .rc_o (rc), .rc_vld_o (rc_vld), .oe_o (oe), .oe_vld_o (oe_vld),
      .ex_flags_o (exf), .lk_o (lk)
   );

   typedef struct packed {
      logic [3:0]  in2;
      logic [4:0]  rd1;  logic rd1v;
      logic [4:0]  rd2;  logic rd2v;
      logic [4:0]  rd3;  logic rd3v;
      logic [9:0]  s1;   logic s1v;
      logic [9:0]  s2;   logic s2v;
      logic [63:0] im;   logic imv;
      logic [4:0]  wr;   logic wrv;
      logic [9:0]  sw;   logic swv;
      logic        rc;   logic rcv;
      logic        oe;   logic oev;
      logic [10:0] fl;   logic lk;
   } exp_t;

   exp_t sb_q[$];
   int   n_chk  = 0;
   int   n_fail = 0;
   bit   done   = 1'b0;

   // independent reference model built from the requirements
   function automatic exp_t model(input logic [31:0] w, input logic [1:0] a1,
                                  input logic [3:0] a2, input logic a3,
                                  input logic [1:0] o, input logic [1:0] r,
                                  input logic [2:0] c, input logic [10:0] f,
                                  input logic le);
      exp_t e;
      logic [9:0] swap;
      logic [63:0] s16;
      e = '0;
      e.in2 = a2;
      swap = {w[15:11], w[20:16]};
      s16 = 64'($signed(w[15:0]));
      // R1
      if (a1 == 2'd1 || (a1 == 2'd2 && w[20:16] != 5'd0)) begin
         e.rd1 = w[20:16]; e.rd1v = 1'b1;
      end
      // R2
      if (a3) begin e.rd3 = w[25:21]; e.rd3v = 1'b1; end
      // R3 / R4
      if ((c == 3'd1 || c == 3'd2) && w[23] == 1'b0) begin
         e.s1 = 10'd9; e.s1v = 1'b1;
      end else if (c == 3'd3 || c == 3'd4) begin
         e.s1 = swap; e.s1v = 1'b1;
      end
      // R5 .. R9, R13
      case (a2)
         4'd1:  begin e.rd2 = w[15:11]; e.rd2v = 1'b1; end
         4'd2:  begin e.im = {48'h0, w[15:0]}; e.imv = 1'b1; end
         4'd3:  begin e.im = s16; e.imv = 1'b1; end
         4'd4:  begin e.im = {32'h0, w[15:0], 16'h0}; e.imv = 1'b1; end
         4'd5:  begin e.im = s16 << 16; e.imv = 1'b1; end
         4'd6:  begin e.im = 64'($signed(w[25:2])) * 4; e.imv = 1'b1; end
         4'd7, 4'd8: begin e.im = 64'($signed(w[15:2])) * 4; e.imv = 1'b1; end
         4'd9:  begin e.im = ~64'h0; e.imv = 1'b1; end
         4'd10: begin e.im = 64'(w[1]) * 32 + 64'(w[15:11]); e.imv = 1'b1; end
         4'd11: begin e.im = 64'(w[15:11]); e.imv = 1'b1; end
         4'd12: begin e.s2 = w[10] ? 10'd9 : 10'd8; e.s2v = 1'b1; end
         default: ;
      endcase
      // R10
      if (o == 2'd1) begin e.wr = w[25:21]; e.wrv = 1'b1; end
      if (o == 2'd2) begin e.wr = w[20:16]; e.wrv = 1'b1; end
      if (o == 2'd3) begin e.sw = swap; e.swv = 1'b1; end
      // R11
      e.rcv = 1'b1;
      e.rc  = (r == 2'd1) ? 1'b1 : ((r == 2'd2) ? w[0] : 1'b0);
      e.oev = 1'b1;
      e.oe  = w[10];
      // R12
      e.fl = f;
      e.lk = le ? w[0] : 1'b0;
      return e;
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
      end
   endtask

   // driver: apply a vector and push its expected result
   task automatic drive(input logic [31:0] w, input logic [1:0] a1,
                        input logic [3:0] a2, input logic a3,
                        input logic [1:0] o, input logic [1:0] r,
                        input logic [2:0] c, input logic [10:0] f,
                        input logic le);
      @(posedge clk);
      #1;
      instr = w; in1 = a1; in2 = a2; in3 = a3; outs = o; rcs = r;
      cls = c; flags = f; lken = le;
      sb_q.push_back(model(w, a1, a2, a3, o, r, c, f, le));
   endtask

   function automatic string imm_tag(input logic [3:0] s, input logic v);
      if (s >= 4'd13) return "R13";
      if (!v) return "R14";
      if (s == 4'd6 || s == 4'd7 || s == 4'd8) return "R8";
      if (s == 4'd4 || s == 4'd5) return "R9";
      return "R7";
   endfunction

   // monitor: compare at the falling edge, away from the driving edge
   initial begin
      exp_t e;
      forever begin
         @(negedge clk);
         if (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            chk(e.rd1v ? "R1" : "R14", "rd1", {58'h0, rd1_vld, rd1_idx},
                {58'h0, e.rd1v, e.rd1});
            chk((e.in2 >= 4'd13) ? "R13" : "R5", "rd2",
                {58'h0, rd2_vld, rd2_idx}, {58'h0, e.rd2v, e.rd2});
            chk("R2", "rd3", {58'h0, rd3_vld, rd3_idx}, {58'h0, e.rd3v, e.rd3});
            chk((e.s1 == 10'd9) ? "R3" : "R4", "sprr1",
                {53'h0, s1_vld, s1_id}, {53'h0, e.s1v, e.s1});
            chk((e.in2 >= 4'd13) ? "R13" : "R6", "sprr2",
                {53'h0, s2_vld, s2_id}, {53'h0, e.s2v, e.s2});
            chk(imm_tag(e.in2, e.imv), "imm", imm, e.im);
            chk(imm_tag(e.in2, e.imv), "imm_vld", {63'h0, imm_vld},
                {63'h0, e.imv});
            chk("R10", "wr", {58'h0, wr_vld, wr_idx}, {58'h0, e.wrv, e.wr});
            chk("R10", "sprw", {53'h0, sw_vld, sw_id}, {53'h0, e.swv, e.sw});
            chk("R11", "rc_oe", {60'h0, rc_vld, rc, oe_vld, oe},
                {60'h0, e.rcv, e.rc, e.oev, e.oe});
            chk("R12", "flags_lk", {52'h0, exf, lk}, {52'h0, e.fl, e.lk});
         end
      end
   end

   // watchdog
   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog act=expired exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      instr = '0; in1 = '0; in2 = '0; in3 = 1'b0; outs = '0; rcs = '0;
      cls = '0; flags = '0; lken = 1'b0;
      repeat (3) @(posedge clk);
      rst = 1'b0;

      // reset-like idle vector: only rc/oe records valid (R11, R14)
      drive(32'h0, 2'd0, 4'd0, 1'b0, 2'd0, 2'd0, 3'd0, 11'h0, 1'b0);
      // R1: zero base suppressed, nonzero base passes, plain RA with zero
      drive(32'h0000_0000, 2'd2, 4'd1, 1'b0, 2'd1, 2'd0, 3'd0, 11'h0, 1'b0);
      drive(32'h0013_0000, 2'd2, 4'd1, 1'b0, 2'd2, 2'd0, 3'd0, 11'h0, 1'b0);
      drive(32'h0000_0000, 2'd1, 4'd0, 1'b1, 2'd0, 2'd0, 3'd0, 11'h0, 1'b0);
      drive(32'h001F_0000, 2'd3, 4'd0, 1'b0, 2'd0, 2'd0, 3'd0, 11'h0, 1'b0);
      // R3: branch with bit 23 clear / set, branch to register
      drive(32'h0200_0000, 2'd0, 4'd7, 1'b0, 2'd0, 2'd0, 3'd1, 11'h0, 1'b1);
      drive(32'h0280_8001, 2'd0, 4'd7, 1'b0, 2'd0, 2'd0, 3'd1, 11'h0, 1'b1);
      drive(32'h0000_0400, 2'd0, 4'd12, 1'b0, 2'd0, 2'd0, 3'd2, 11'h0, 1'b1);
      // R6: link register selection
      drive(32'h0080_0000, 2'd0, 4'd12, 1'b0, 2'd0, 2'd0, 3'd2, 11'h0, 1'b0);
      // R4 / R10: move from and move to special register, swapped halves
      drive(32'h03E1_4800, 2'd0, 4'd0, 1'b0, 2'd1, 2'd0, 3'd3, 11'h0, 1'b0);
      drive(32'h03E1_4800, 2'd0, 4'd0, 1'b1, 2'd3, 2'd0, 3'd4, 11'h0, 1'b0);
      // R7 / R8 / R9: negative immediates in each shift and extension form
      drive(32'h0000_8001, 2'd0, 4'd2, 1'b0, 2'd0, 2'd1, 3'd0, 11'h0, 1'b0);
      drive(32'h0000_8001, 2'd0, 4'd3, 1'b0, 2'd0, 2'd2, 3'd0, 11'h0, 1'b0);
      drive(32'h0000_8001, 2'd0, 4'd4, 1'b0, 2'd0, 2'd3, 3'd0, 11'h0, 1'b0);
      drive(32'h0000_8001, 2'd0, 4'd5, 1'b0, 2'd0, 2'd0, 3'd0, 11'h0, 1'b0);
      drive(32'h0200_0004, 2'd0, 4'd6, 1'b0, 2'd0, 2'd0, 3'd0, 11'h0, 1'b0);
      drive(32'h0000_FFFC, 2'd0, 4'd8, 1'b0, 2'd0, 2'd0, 3'd0, 11'h0, 1'b0);
      drive(32'h0000_0000, 2'd0, 4'd9, 1'b0, 2'd0, 2'd0, 3'd0, 11'h0, 1'b0);
      drive(32'h0000_F802, 2'd0, 4'd10, 1'b0, 2'd0, 2'd0, 3'd0, 11'h0, 1'b0);
      drive(32'h0000_F802, 2'd0, 4'd11, 1'b0, 2'd0, 2'd0, 3'd0, 11'h0, 1'b0);
      // R13: undefined second-operand codes
      drive(32'hFFFF_FFFF, 2'd0, 4'd13, 1'b0, 2'd0, 2'd0, 3'd0, 11'h0, 1'b0);
      drive(32'hFFFF_FFFF, 2'd0, 4'd15, 1'b0, 2'd0, 2'd0, 3'd0, 11'h0, 1'b0);
      // R12: flags pass through, link gated
      drive(32'h0000_0001, 2'd0, 4'd0, 1'b0, 2'd0, 2'd0, 3'd0, 11'h5A5, 1'b0);
      drive(32'h0000_0001, 2'd0, 4'd0, 1'b0, 2'd0, 2'd0, 3'd0, 11'h25A, 1'b1);

      // random sweep over instructions and selector combinations
      for (int i = 0; i < N_RANDOM; i++) begin
         drive($urandom, 2'($urandom), 4'($urandom), 1'($urandom),
               2'($urandom), 2'($urandom), 3'($urandom), 11'($urandom),
               1'($urandom));
      end

      while (sb_q.size() > 0) @(posedge clk);
      @(posedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule